// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Word-Select Generator

This block produces the two timing signals that a serial audio link master drives: a bit clock and a word-select line. Both come from the system clock. A programmable integer divider sets the bit-clock period. A small configuration word selects how many bit clocks make up each word-select half. The same word can also suppress the bit clock for the tail of every half. Downstream serializers do not sample the derived clock. Instead they use two single-cycle strobes, one aligned to each bit-clock rising edge and one aligned to each falling edge.

Two enables gate the block. The core enable is the master switch. The clock enable starts and stops generation within an enabled core. While either enable is low, all outputs rest low and the configuration and divider inputs are captured. Every start therefore begins cleanly from the left half with the settings seen just before it. Configuration inputs are ignored while generation runs.

Top module: `sclk_ws_gen`

## Requirements
- R1: When no gating applies, the bit clock stays high for exactly N system cycles and low for N system cycles, where N is the value on `half_div`. A value of 0 is treated as 1.
- R2: Configuration bits [4:3] set the number of bit-clock periods per word-select half: code 0 gives 16, code 1 gives 24, and codes 2 and 3 give 32. Each word-select level therefore lasts that count times 2N system cycles.
- R3: After a start, word-select is 0 (left) first. It toggles only in a cycle where the bit clock is low, right after the last bit period of a half ends. When the bit clock is not gated, that cycle also carries `fall_stb`.
- R4: Configuration bits [2:0] with codes 1, 2, 3 and 4 let only the first 12, 16, 20 and 24 bit-clock pulses of each half through. The bit clock is held low for the rest of the half, and the half length is unchanged.
- R5: Gating codes 0, 5, 6 and 7 leave the bit clock running freely. A gating count equal to or larger than the half length also has no effect.
- R6: With `clk_en` at 0, the bit clock, word-select and both strobes are 0 from the next cycle on. `cfg` and `half_div` are sampled only while generation is stopped, and changes made while it runs are ignored.
- R7: With `core_en` at 0, the block stays idle whatever `clk_en` is. Raising `core_en` again restarts from the left half.
- R8: `rise_stb` is high exactly in the first cycle of each visible bit-clock high phase. `fall_stb` is high exactly in the first low cycle after a visible high phase. Suppressed pulses produce no strobe.
- R9: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_en | input | 1 | Master enable for all clock activity |
| clk_en | input | 1 | Starts (1) or stops (0) generation |
| cfg | input | 5 | [4:3] half-length code, [2:0] gating code |
| half_div | input | DIV_W | System cycles per bit-clock phase (0 acts as 1) |
| sclk | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 left, 1 right |
| rise_stb | output | 1 | One-cycle strobe at each visible bit-clock rise |
| fall_stb | output | 1 | One-cycle strobe at each visible bit-clock fall |

## Verification
The word-select toggle and the end of a gating window share a system cycle. With gating active, the final bit period of a half is suppressed, so word-select flips while the bit clock is held low. The first pulse of the new half must then appear at once. The bench provokes this with gated configurations such as 24 pulses in a 32-period half, and measures two consecutive halves. It judges the pulse count in each half, the exact half length in system cycles, and that no strobe is produced alongside a word-select flip in a gated half.

// File: rtl/sclkgen_pkg.sv
package sclkgen_pkg;

  localparam int CNT_W = 6;

  typedef logic [CNT_W-1:0] bcnt_t;

  // cfg[4:3] is the half-length code, cfg[2:0] the gating code
  typedef struct packed {
    logic [1:0] wsz;
    logic [2:0] gsel;
  } frame_cfg_t;

  // bit-clock periods in one word-select half; code 3 maps to 32
  function automatic bcnt_t half_len(input logic [1:0] code);
    case (code)
      2'd0:    return bcnt_t'(16);
      2'd1:    return bcnt_t'(24);
      default: return bcnt_t'(32);
    endcase
  endfunction

  // pulses allowed per half; 0 means no gating (codes 0 and 5..7)
  function automatic bcnt_t gate_len(input logic [2:0] code);
    case (code)
      3'd1:    return bcnt_t'(12);
      3'd2:    return bcnt_t'(16);
      3'd3:    return bcnt_t'(20);
      3'd4:    return bcnt_t'(24);
      default: return bcnt_t'(0);
    endcase
  endfunction

  // a bit period is suppressed once the allowed count is reached
  function automatic logic gate_active(input bcnt_t idx, input bcnt_t half,
                                       input bcnt_t gate);
    return (gate != bcnt_t'(0)) && (gate < half) && (idx >= gate);
  endfunction

endpackage

// File: rtl/sclkgen_prescale.sv
module sclkgen_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] lim,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == lim - {{(DIV_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  // R1: phase counter never passes the divisor while running
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < lim));

endmodule

// File: rtl/sclkgen_frame.sv
module sclkgen_frame
  import sclkgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  frame_cfg_t fcfg,
  output logic       ph,
  output logic       ws,
  output logic       gated,
  output logic       rise_evt,
  output logic       fall_evt
);

  bcnt_t half;
  bcnt_t gate;
  bcnt_t bit_idx;
  logic  last_bit;

  assign half     = half_len(fcfg.wsz);
  assign gate     = gate_len(fcfg.gsel);
  assign gated    = gate_active(bit_idx, half, gate);
  assign rise_evt = tick && !ph;
  assign fall_evt = tick && ph;
  assign last_bit = (bit_idx == half - bcnt_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ph      <= 1'b0;
      ws      <= 1'b0;
      bit_idx <= '0;
    end else if (rise_evt) begin
      ph <= 1'b1;
    end else if (fall_evt) begin
      ph <= 1'b0;
      if (last_bit) begin
        bit_idx <= '0;
        ws      <= ~ws;
      end else begin
        bit_idx <= bit_idx + bcnt_t'(1);
      end
    end
  end

  // R2: word select flips only after the final bit period of a half
  assert_ws_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (ws != $past(ws))) |->
      ($past(bit_idx) == $past(half) - bcnt_t'(1)));

  // R4: the bit counter restarts together with the word-select flip
  assert_idx_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (ws != $past(ws))) |-> (bit_idx == '0));

endmodule

// File: rtl/sclk_ws_gen.sv
module sclk_ws_gen
  import sclkgen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_en,
  input  logic             clk_en,
  input  logic [4:0]       cfg,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             ws,
  output logic             rise_stb,
  output logic             fall_stb
);

  localparam logic [DIV_W-1:0] DIV_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic             run;
  frame_cfg_t       cfg_sh;
  logic [DIV_W-1:0] div_sh;
  logic             tick;
  logic             ph;
  logic             gated;
  logic             rise_evt;
  logic             fall_evt;
  logic             sclk_q;
  logic             rise_q;
  logic             fall_q;

  assign run = core_en && clk_en;

  // settings are captured only while generation is stopped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_sh <= '0;
      div_sh <= DIV_ONE;
    end else if (!run) begin
      cfg_sh <= frame_cfg_t'(cfg);
      div_sh <= (half_div == '0) ? DIV_ONE : half_div;
    end
  end

  sclkgen_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .lim   (div_sh),
    .tick  (tick)
  );

  sclkgen_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .fcfg     (cfg_sh),
    .ph       (ph),
    .ws       (ws),
    .gated    (gated),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_evt && !gated;
      fall_q <= fall_evt && sclk_q;
      if (!run)                    sclk_q <= 1'b0;
      else if (rise_evt && !gated) sclk_q <= 1'b1;
      else if (fall_evt)           sclk_q <= 1'b0;
    end
  end

  assign sclk     = sclk_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;

  // R4: visible clock stays low for the suppressed part of a half
  assert_gated_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gated |-> !sclk);

  // R1: visible clock is high only inside an internal high phase
  assert_sclk_in_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> ph);

  // R6: stopping clears every output on the following cycle
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sclk && !ws && !rise_stb && !fall_stb));

  // R8: strobes mark real edges of the visible clock
  assert_rise_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (sclk && !$past(sclk)));
  assert_fall_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!sclk && $past(sclk)));

  // R3: word select moves only while the visible clock is low
  assert_ws_low_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (ws != $past(ws))) |-> !sclk);

endmodule

// File: tb/sclk_ws_gen_bench.sv
module sclk_ws_gen_bench;

  typedef struct packed {
    logic [1:0] wsz;
    logic [2:0] gsel;
    logic [7:0] dv;
    logic [7:0] hl;
    logic [7:0] rs;
  } vec_t;

  // half-length code, gating code, divider, expected periods, expected pulses
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 8'd1, 8'd16, 8'd16},  // R2 R5 free, 16
    '{2'd1, 3'd0, 8'd2, 8'd24, 8'd24},  // R2 24
    '{2'd2, 3'd0, 8'd1, 8'd32, 8'd32},  // R2 32
    '{2'd3, 3'd0, 8'd3, 8'd32, 8'd32},  // R2 reserved code as 32
    '{2'd0, 3'd1, 8'd1, 8'd16, 8'd12},  // R4 gate 12
    '{2'd1, 3'd2, 8'd2, 8'd24, 8'd16},  // R4 gate 16
    '{2'd2, 3'd3, 8'd1, 8'd32, 8'd20},  // R4 gate 20
    '{2'd2, 3'd4, 8'd1, 8'd32, 8'd24},  // R4 gate 24
    '{2'd1, 3'd4, 8'd1, 8'd24, 8'd24},  // R5 gate equals half
    '{2'd0, 3'd4, 8'd1, 8'd16, 8'd16},  // R5 gate beyond half
    '{2'd0, 3'd5, 8'd1, 8'd16, 8'd16},  // R5 reserved gate code
    '{2'd2, 3'd7, 8'd2, 8'd32, 8'd32},  // R5 reserved gate code
    '{2'd0, 3'd0, 8'd0, 8'd16, 8'd16}   // R1 divider 0 acts as 1
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       core_en = 1'b0;
  logic       clk_en = 1'b0;
  logic [4:0] cfg = '0;
  logic [7:0] half_div = 8'd1;
  logic       sclk, ws, rise_stb, fall_stb;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  bit mon_free = 1'b0;
  int mon_err = 0;
  logic p_sclk = 1'b0;
  logic p_ws = 1'b0;

  sclk_ws_gen #(.DIV_W(8)) u_sclk_ws_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_en  (core_en),
    .clk_en   (clk_en),
    .cfg      (cfg),
    .half_div (half_div),
    .sclk     (sclk),
    .ws       (ws),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  always #2 clk = ~clk;

  // edge monitor for R8 strobes and R3 word-select alignment
  always @(negedge clk) begin
    if (mon_on) begin
      if (rise_stb !== (sclk && !p_sclk)) mon_err++;
      if (fall_stb !== (!sclk && p_sclk)) mon_err++;
      if (ws !== p_ws) begin
        if (sclk !== 1'b0) mon_err++;
        if (mon_free && !fall_stb) mon_err++;
      end
    end
    p_sclk = sclk;
    p_ws = ws;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_lvl(input logic lvl);
    int n = 0;
    while (ws !== lvl && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) chk("R3 word select never reached level", 0, 1);
  endtask

  task automatic measure(output int cyc, output int rs);
    logic lvl = ws;
    logic pv = sclk;
    cyc = 0;
    rs = 0;
    while (ws === lvl && cyc < 4000) begin
      cyc++;
      @(negedge clk);
      if (sclk && !pv) rs++;
      pv = sclk;
    end
  endtask

  task automatic high_width(output int w);
    int n = 0;
    while (sclk !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    w = 0;
    while (sclk === 1'b1 && w < 4000) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic idle_activity(output int act);
    act = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk || ws || rise_stb || fall_stb) act++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int n, c1, r1, c2, r2, w, e0, exp_len;
    n = (v.dv == 8'd0) ? 1 : int'(v.dv);
    exp_len = int'(v.hl) * 2 * n;
    clk_en = 1'b0;
    @(negedge clk);
    cfg = {v.wsz, v.gsel};
    half_div = v.dv;
    repeat (2) @(negedge clk);
    e0 = mon_err;
    mon_free = (v.rs == v.hl);
    clk_en = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    chk("R3 left half first", int'(ws), 0);
    wait_lvl(1'b1);
    measure(c1, r1);
    measure(c2, r2);
    chk("R2 right half length", c1, exp_len);
    chk("R2 left half length", c2, exp_len);
    if (v.rs != v.hl) begin
      chk("R4 pulses in right half", r1, int'(v.rs));
      chk("R4 pulses in left half", r2, int'(v.rs));
    end else begin
      chk("R5 pulses in right half", r1, int'(v.rs));
      chk("R5 pulses in left half", r2, int'(v.rs));
    end
    high_width(w);
    chk("R1 high phase width", w, n);
    mon_on = 1'b0;
    chk("R8 strobe and R3 edge monitor errors", mon_err - e0, 0);
  endtask

  initial begin
    int c, r, act;
    // R9: outputs stay low while reset is held, even with both enables set
    core_en = 1'b1;
    clk_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 reset outputs", int'({sclk, ws, rise_stb, fall_stb}), 0);
    clk_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R6: configuration changed while running is ignored
    clk_en = 1'b0;
    @(negedge clk);
    cfg = 5'b00_000;
    half_div = 8'd1;
    repeat (2) @(negedge clk);
    clk_en = 1'b1;
    @(negedge clk);
    cfg = 5'b10_011;
    half_div = 8'd3;
    wait_lvl(1'b1);
    measure(c, r);
    chk("R6 half length after live change", c, 32);
    chk("R6 pulses after live change", r, 16);

    // R6: stopped generation leaves all outputs low
    clk_en = 1'b0;
    idle_activity(act);
    chk("R6 idle activity", act, 0);

    // R7: core disable overrides clock enable
    cfg = 5'b00_000;
    half_div = 8'd2;
    core_en = 1'b0;
    clk_en = 1'b1;
    idle_activity(act);
    chk("R7 idle with core off", act, 0);
    core_en = 1'b1;
    @(negedge clk);
    chk("R7 restart in left half", int'(ws), 0);
    wait_lvl(1'b1);
    measure(c, r);
    chk("R7 half length after restart", c, 64);
    chk("R7 pulses after restart", r, 16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule